// File: doc/BRIEF.md
# Card Attribute Control and Status Registers

This block is the small register file that a removable flash memory card exposes in its attribute space. The host reaches it by pulling the attribute-select line low and issuing a single-cycle write or read strobe with an address. Two write-only registers control the flash array. The option register carries a soft-reset bit, which drives `soft_reset_out` and stops array accesses through `array_enable`. The configuration register carries a power-down bit, which drives `power_down_out`. A read-only status register reports both control bits. It also reports the flash array's ready/busy line, after that line has passed through a two-flop synchroniser.

The two control bits are held as one four-state mode machine. `MODE_RUN` has both bits clear. `MODE_SLEEP` has only power-down set. `MODE_HALT` has only soft reset set. `MODE_HALT_SLEEP` has both set. The named transitions are:
- SET_HALT: RUN→HALT or SLEEP→HALT_SLEEP, on an option write with bit 7 = 1.
- END_HALT: HALT→RUN or HALT_SLEEP→SLEEP, on an option write with bit 7 = 0.
- SET_SLEEP: RUN→SLEEP or HALT→HALT_SLEEP, on a configuration write with bit 2 = 1.
- WAKE: SLEEP→RUN or HALT_SLEEP→HALT, on a configuration write with bit 2 = 0.
- CARD_RESET: any state→RUN, while `card_reset` is high.

Writes that match the bit a state already holds leave that state unchanged. Read data is registered and appears the cycle after the read strobe. In every other cycle the read data is 0x00.

Top module: `card_cfg_regs`

## Requirements
- R1: After the power-on reset (`rst_n` low) is released, `soft_reset_out`=0, `power_down_out`=0, `array_enable`=1 and `rdata`=0x00.
- R2: A write with `attr_sel_n`=0 and `wr_en`=1 to address 0x4000 sets `soft_reset_out` to `wdata` bit 7 from the next clock edge on. `wdata` bits 6..0 have no effect.
- R3: A write with `attr_sel_n`=0 and `wr_en`=1 to address 0x4002 sets `power_down_out` to `wdata` bit 2 from the next clock edge on. All other `wdata` bits have no effect.
- R4: A read with `attr_sel_n`=0 and `rd_en`=1 at address 0x4100 returns the status byte on `rdata` after the next clock edge. In that byte, bit 5 is soft reset, bit 3 is power down and bit 0 is synchronised ready (1 = ready). Bits 7, 6, 4, 2 and 1 are 0.
- R5: Status bit 0 returns the `rb_ready` value sampled two clock edges before the edge that captures the read. A change on `rb_ready` is therefore first seen by a read strobe held over the third edge after the change.
- R6: `array_enable` is the inverse of `soft_reset_out`. Register writes are still accepted while soft reset is active, so writing 0 to bit 7 of 0x4000 ends it.
- R7: A read of any address other than 0x4100 (including the write-only 0x4000 and 0x4002) returns 0x00. `rdata` is 0x00 in every cycle that follows a cycle with no read strobe.
- R8: Strobes with `attr_sel_n`=1 change neither control output nor `rdata`. `rdata` stays 0x00.
- R9: `card_reset` high at a clock edge clears both control bits and `rdata`, whatever access is presented in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| card_reset | input | 1 | Synchronous card reset from the host, active high |
| attr_sel_n | input | 1 | Attribute space select, active low |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | ADDR_W (15) | Attribute byte address |
| wdata | input | DATA_W (8) | Write data |
| rb_ready | input | 1 | Asynchronous ready/busy from the flash array, 1 = ready |
| rdata | output | DATA_W (8) | Registered read data |
| soft_reset_out | output | 1 | Soft reset to the flash array |
| power_down_out | output | 1 | Power-down request to the flash array |
| array_enable | output | 1 | High when array accesses are allowed |

## Verification
The properties assume that `wr_en`, `rd_en`, `addr`, `wdata`, `attr_sel_n` and `card_reset` are synchronous to `clk` and settle well before each rising edge. Only `rb_ready` may change at any time. The bench drives every input on the falling edge. It changes `rb_ready` on falling edges too, at arbitrary cycles with no relation to the strobes. The randomised phase mixes deselected strobes, simultaneous read and write strobes, and `card_reset` pulses that collide with accesses. The assertions judge these collisions by the rule that card reset overrides any access presented in the same cycle.

// File: rtl/card_cfg_pkg.sv
package card_cfg_pkg;

    // Write-data bit positions decoded by the control registers
    localparam int unsigned SR_WBIT = 7;
    localparam int unsigned PD_WBIT = 2;

    // Status byte bit positions
    localparam int unsigned ST_SR_BIT = 5;
    localparam int unsigned ST_PD_BIT = 3;
    localparam int unsigned ST_RB_BIT = 0;

    // Combined array control mode
    typedef enum logic [1:0] {
        MODE_RUN        = 2'd0,
        MODE_SLEEP      = 2'd1,
        MODE_HALT       = 2'd2,
        MODE_HALT_SLEEP = 2'd3
    } card_mode_e;

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode #(
    parameter int unsigned ADDR_W   = 15,
    parameter int unsigned OPT_OFS  = 'h4000,
    parameter int unsigned CSR_OFS  = 'h4002,
    parameter int unsigned STAT_OFS = 'h4100
) (
    input  logic              attr_sel_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_opt_wr,
    output logic              hit_csr_wr,
    output logic              hit_stat_rd
);

    localparam logic [ADDR_W-1:0] OPT_A  = ADDR_W'(OPT_OFS);
    localparam logic [ADDR_W-1:0] CSR_A  = ADDR_W'(CSR_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

    logic sel_wr;
    logic sel_rd;

    always_comb begin
        sel_wr      = !attr_sel_n && wr_en;
        sel_rd      = !attr_sel_n && rd_en;
        hit_opt_wr  = sel_wr && (addr == OPT_A);
        hit_csr_wr  = sel_wr && (addr == CSR_A);
        hit_stat_rd = sel_rd && (addr == STAT_A);
    end

endmodule

// File: rtl/cfg_rb_sync.sv
module cfg_rb_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/cfg_mode_fsm.sv
module cfg_mode_fsm
    import card_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic card_reset,
    input  logic hit_opt_wr,
    input  logic hit_csr_wr,
    input  logic sr_val,
    input  logic pd_val,
    output logic soft_reset,
    output logic power_down,
    output logic array_enable
);

    card_mode_e state_q;
    card_mode_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: SET_HALT, END_HALT, SET_SLEEP, WAKE, CARD_RESET
    always_comb begin
        state_d = state_q;
        if (card_reset) begin
            state_d = MODE_RUN;
        end else begin
            unique case (state_q)
                MODE_RUN: begin
                    if (hit_opt_wr && sr_val)      state_d = MODE_HALT;
                    else if (hit_csr_wr && pd_val) state_d = MODE_SLEEP;
                end
                MODE_SLEEP: begin
                    if (hit_opt_wr && sr_val)       state_d = MODE_HALT_SLEEP;
                    else if (hit_csr_wr && !pd_val) state_d = MODE_RUN;
                end
                MODE_HALT: begin
                    if (hit_opt_wr && !sr_val)     state_d = MODE_RUN;
                    else if (hit_csr_wr && pd_val) state_d = MODE_HALT_SLEEP;
                end
                MODE_HALT_SLEEP: begin
                    if (hit_opt_wr && !sr_val)      state_d = MODE_SLEEP;
                    else if (hit_csr_wr && !pd_val) state_d = MODE_HALT;
                end
                default: state_d = MODE_RUN;
            endcase
        end
    end

    // Outputs decoded from the held mode
    always_comb begin
        soft_reset   = 1'b0;
        power_down   = 1'b0;
        array_enable = 1'b1;
        unique case (state_q)
            MODE_RUN: begin
            end
            MODE_SLEEP: begin
                power_down = 1'b1;
            end
            MODE_HALT: begin
                soft_reset   = 1'b1;
                array_enable = 1'b0;
            end
            MODE_HALT_SLEEP: begin
                soft_reset   = 1'b1;
                power_down   = 1'b1;
                array_enable = 1'b0;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/cfg_read_port.sv
module cfg_read_port
    import card_cfg_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              card_reset,
    input  logic              hit_stat_rd,
    input  logic              soft_reset,
    input  logic              power_down,
    input  logic              rb_sync,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] status_byte;

    always_comb begin
        status_byte            = '0;
        status_byte[ST_SR_BIT] = soft_reset;
        status_byte[ST_PD_BIT] = power_down;
        status_byte[ST_RB_BIT] = rb_sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (card_reset) begin
            rdata <= '0;
        end else if (hit_stat_rd) begin
            rdata <= status_byte;
        end else begin
            rdata <= '0;
        end
    end

endmodule

// File: rtl/card_cfg_regs.sv
module card_cfg_regs
    import card_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W      = 15,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned OPT_OFS     = 'h4000,
    parameter int unsigned CSR_OFS     = 'h4002,
    parameter int unsigned STAT_OFS    = 'h4100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              card_reset,
    input  logic              attr_sel_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rb_ready,
    output logic [DATA_W-1:0] rdata,
    output logic              soft_reset_out,
    output logic              power_down_out,
    output logic              array_enable
);

    logic hit_opt_wr;
    logic hit_csr_wr;
    logic hit_stat_rd;
    logic rb_sync;
    logic unused_wdata;

    assign unused_wdata = ^wdata;

    cfg_addr_decode #(
        .ADDR_W   (ADDR_W),
        .OPT_OFS  (OPT_OFS),
        .CSR_OFS  (CSR_OFS),
        .STAT_OFS (STAT_OFS)
    ) u_decode (
        .attr_sel_n  (attr_sel_n),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .hit_opt_wr  (hit_opt_wr),
        .hit_csr_wr  (hit_csr_wr),
        .hit_stat_rd (hit_stat_rd)
    );

    cfg_rb_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (rb_ready),
        .sync_out (rb_sync)
    );

    cfg_mode_fsm u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .card_reset   (card_reset),
        .hit_opt_wr   (hit_opt_wr),
        .hit_csr_wr   (hit_csr_wr),
        .sr_val       (wdata[SR_WBIT]),
        .pd_val       (wdata[PD_WBIT]),
        .soft_reset   (soft_reset_out),
        .power_down   (power_down_out),
        .array_enable (array_enable)
    );

    cfg_read_port #(
        .DATA_W (DATA_W)
    ) u_read (
        .clk         (clk),
        .rst_n       (rst_n),
        .card_reset  (card_reset),
        .hit_stat_rd (hit_stat_rd),
        .soft_reset  (soft_reset_out),
        .power_down  (power_down_out),
        .rb_sync     (rb_sync),
        .rdata       (rdata)
    );

endmodule

// File: rtl/cfg_regs_checker.sv
module cfg_regs_checker
    import card_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W   = 15,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned OPT_OFS  = 'h4000,
    parameter int unsigned CSR_OFS  = 'h4002,
    parameter int unsigned STAT_OFS = 'h4100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              card_reset,
    input logic              attr_sel_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              soft_reset_out,
    input logic              power_down_out,
    input logic              array_enable
);

    localparam logic [ADDR_W-1:0] OPT_A  = ADDR_W'(OPT_OFS);
    localparam logic [ADDR_W-1:0] CSR_A  = ADDR_W'(CSR_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
    localparam logic [DATA_W-1:0] LIVE_BITS =
        (DATA_W'(1) << ST_SR_BIT) | (DATA_W'(1) << ST_PD_BIT) | (DATA_W'(1) << ST_RB_BIT);
    localparam logic [DATA_W-1:0] RSVD_MASK = ~LIVE_BITS;

    logic opt_wr;
    logic csr_wr;
    logic stat_rd;

    assign opt_wr  = !attr_sel_n && wr_en && (addr == OPT_A);
    assign csr_wr  = !attr_sel_n && wr_en && (addr == CSR_A);
    assign stat_rd = !attr_sel_n && rd_en && (addr == STAT_A);

    assert_por_idle_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!soft_reset_out && !power_down_out && array_enable && rdata == '0));

    assert_soft_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (opt_wr && !card_reset) |=> (soft_reset_out == $past(wdata[SR_WBIT])));

    assert_pd_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && !card_reset) |=> (power_down_out == $past(wdata[PD_WBIT])));

    assert_status_mirror_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !card_reset) |=> (rdata[ST_SR_BIT] == $past(soft_reset_out)
                                      && rdata[ST_PD_BIT] == $past(power_down_out)
                                      && (rdata & RSVD_MASK) == '0));

    assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        array_enable != soft_reset_out);

    assert_idle_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_rd) |=> (rdata == '0));

    assert_deselect_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!card_reset && (attr_sel_n || !wr_en))
            |=> ($stable(soft_reset_out) && $stable(power_down_out)));

    assert_card_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        card_reset |=> (!soft_reset_out && !power_down_out && rdata == '0));

endmodule

bind card_cfg_regs cfg_regs_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .OPT_OFS  (OPT_OFS),
    .CSR_OFS  (CSR_OFS),
    .STAT_OFS (STAT_OFS)
) i_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .card_reset     (card_reset),
    .attr_sel_n     (attr_sel_n),
    .wr_en          (wr_en),
    .rd_en          (rd_en),
    .addr           (addr),
    .wdata          (wdata),
    .rdata          (rdata),
    .soft_reset_out (soft_reset_out),
    .power_down_out (power_down_out),
    .array_enable   (array_enable)
);

// File: tb/test_card_cfg_regs.sv
module test_card_cfg_regs;

    localparam int AW = 15;
    localparam int DW = 8;
    localparam logic [AW-1:0] A_OPT  = 15'h4000;
    localparam logic [AW-1:0] A_CSR  = 15'h4002;
    localparam logic [AW-1:0] A_STAT = 15'h4100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          card_reset = 1'b0;
    logic          attr_sel_n = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          rb_ready = 1'b1;
    logic [DW-1:0] rdata;
    logic          soft_reset_out;
    logic          power_down_out;
    logic          array_enable;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    card_cfg_regs i_card_cfg_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .card_reset     (card_reset),
        .attr_sel_n     (attr_sel_n),
        .wr_en          (wr_en),
        .rd_en          (rd_en),
        .addr           (addr),
        .wdata          (wdata),
        .rb_ready       (rb_ready),
        .rdata          (rdata),
        .soft_reset_out (soft_reset_out),
        .power_down_out (power_down_out),
        .array_enable   (array_enable)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge
    logic       m_sr;
    logic       m_pd;
    logic [7:0] m_rd;
    logic       rb_hist[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sr = 1'b0;
            m_pd = 1'b0;
            m_rd = 8'h00;
            rb_hist = {1'b0, 1'b0};
        end else begin
            logic rb_seen;
            rb_seen = rb_hist.pop_front();
            rb_hist.push_back(rb_ready);
            if (card_reset) begin
                m_sr = 1'b0;
                m_pd = 1'b0;
                m_rd = 8'h00;
            end else begin
                if (!attr_sel_n && rd_en && addr == A_STAT)
                    m_rd = {2'b00, m_sr, 1'b0, m_pd, 2'b00, rb_seen};
                else
                    m_rd = 8'h00;
                if (!attr_sel_n && wr_en && addr == A_OPT) m_sr = wdata[7];
                if (!attr_sel_n && wr_en && addr == A_CSR) m_pd = wdata[2];
            end
        end
    end

    // Compare against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 model soft_reset_out", {7'b0, soft_reset_out}, {7'b0, m_sr});
            check("R3 model power_down_out", {7'b0, power_down_out}, {7'b0, m_pd});
            check("R6 model array_enable", {7'b0, array_enable}, {7'b0, !m_sr});
            check("R4 model rdata", rdata, m_rd);
        end
    end

    task automatic idle();
        attr_sel_n = 1'b1;
        wr_en = 1'b0;
        rd_en = 1'b0;
        card_reset = 1'b0;
    endtask

    task automatic write_reg(input logic [AW-1:0] a, input logic [7:0] d, input logic sel_n);
        @(negedge clk);
        attr_sel_n = sel_n;
        wr_en = 1'b1;
        addr = a;
        wdata = d;
        @(negedge clk);
        idle();
    endtask

    task automatic read_reg(input logic [AW-1:0] a, input logic sel_n);
        @(negedge clk);
        attr_sel_n = sel_n;
        rd_en = 1'b1;
        addr = a;
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        check("R1 soft_reset_out", {7'b0, soft_reset_out}, 8'h00);
        check("R1 power_down_out", {7'b0, power_down_out}, 8'h00);
        check("R1 array_enable", {7'b0, array_enable}, 8'h01);
        check("R1 rdata", rdata, 8'h00);

        // R2 / R6: enter soft reset
        write_reg(A_OPT, 8'h80, 1'b0);
        check("R2 soft reset set", {7'b0, soft_reset_out}, 8'h01);
        check("R6 array blocked", {7'b0, array_enable}, 8'h00);
        read_reg(A_STAT, 1'b0);
        check("R4 status in soft reset", rdata, 8'h21);

        // R3: power down
        write_reg(A_CSR, 8'h04, 1'b0);
        check("R3 power down set", {7'b0, power_down_out}, 8'h01);
        read_reg(A_STAT, 1'b0);
        check("R4 status both set", rdata, 8'h29);

        // R2 / R6: clear soft reset while halted, other bits set and ignored
        write_reg(A_OPT, 8'h7F, 1'b0);
        check("R2 soft reset cleared", {7'b0, soft_reset_out}, 8'h00);
        check("R6 write accepted in reset", {7'b0, array_enable}, 8'h01);
        check("R2 power down untouched", {7'b0, power_down_out}, 8'h01);

        // R3: clear power down, other bits set
        write_reg(A_CSR, 8'hFB, 1'b0);
        check("R3 power down cleared", {7'b0, power_down_out}, 8'h00);
        check("R3 soft reset untouched", {7'b0, soft_reset_out}, 8'h00);

        // R8: deselected strobes ignored
        write_reg(A_OPT, 8'h80, 1'b1);
        check("R8 deselected write", {7'b0, soft_reset_out}, 8'h00);
        write_reg(A_CSR, 8'h04, 1'b1);
        check("R8 deselected write pd", {7'b0, power_down_out}, 8'h00);
        read_reg(A_STAT, 1'b1);
        check("R8 deselected read", rdata, 8'h00);

        // R7: other addresses read zero, idle read data zero
        read_reg(A_OPT, 1'b0);
        check("R7 read write-only option", rdata, 8'h00);
        read_reg(A_CSR, 1'b0);
        check("R7 read write-only config", rdata, 8'h00);
        read_reg(15'h1234, 1'b0);
        check("R7 read unmapped", rdata, 8'h00);
        read_reg(A_STAT, 1'b0);
        @(negedge clk);
        check("R7 idle after read", rdata, 8'h00);

        // R5: synchroniser latency with a held read strobe
        @(negedge clk);
        attr_sel_n = 1'b0;
        rd_en = 1'b1;
        addr = A_STAT;
        rb_ready = 1'b0;
        @(negedge clk);
        check("R5 first edge old value", rdata, 8'h01);
        @(negedge clk);
        check("R5 second edge old value", rdata, 8'h01);
        @(negedge clk);
        check("R5 third edge new value", rdata, 8'h00);
        idle();
        rb_ready = 1'b1;
        repeat (3) @(negedge clk);

        // R9: card reset overrides a concurrent access
        write_reg(A_OPT, 8'h80, 1'b0);
        write_reg(A_CSR, 8'h04, 1'b0);
        @(negedge clk);
        card_reset = 1'b1;
        attr_sel_n = 1'b0;
        rd_en = 1'b1;
        addr = A_STAT;
        @(negedge clk);
        idle();
        check("R9 soft reset cleared", {7'b0, soft_reset_out}, 8'h00);
        check("R9 power down cleared", {7'b0, power_down_out}, 8'h00);
        check("R9 rdata cleared", rdata, 8'h00);

        // Randomised traffic checked by the model every cycle
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            attr_sel_n = ($urandom % 4) == 0;
            wr_en = ($urandom % 3) == 0;
            rd_en = ($urandom % 2) == 0;
            case ($urandom % 4)
                0: addr = A_OPT;
                1: addr = A_CSR;
                2: addr = A_STAT;
                default: addr = AW'($urandom);
            endcase
            wdata = 8'($urandom);
            rb_ready = ($urandom % 5) != 0;
            card_reset = ($urandom % 40) == 0;
        end
        @(negedge clk);
        idle();
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule